// File: doc/BRIEF.md
# Four-Channel Prescaled Delay Timer

This block holds four independent 8-bit down-counting delay timers, called A, B, C and D. Each timer divides a shared timer-clock enable through its own prescaler. On every prescaler stroke its count drops by one. When a decrement starts from a count of one, the count reloads from the timer's reload value and the block raises a one-cycle timeout pulse on that timer's output bit. Software sets each timer up through a byte-wide register port. A control field picks the division ratio or stops the timer. A data register sets the reload value, and reading that register returns the live count.

Timers A and B each have a 4-bit control register of their own. Timers C and D share one control byte, which holds two 3-bit prescaler fields. A reload value of zero means a period of 256. Writing a data register while its timer is stopped also sets the current count. Writing it while the timer runs only changes what the next expiry reloads. Event-counting and pulse-width modes are not part of this block. Control values that would pick them leave the timer stopped.

Top module: `dtmr_quad`

## Requirements
- R1: After reset, every control field is 0, every count and reload value is 256, and all timeout outputs are low.
- R2: A write to address 0 (timer A) or address 1 (timer B) stores only data bits 3:0. A write to address 2 stores bits 6:4 as the timer C field and bits 2:0 as the timer D field, so a read of address 2 returns the written byte ANDed with 0x77.
- R3: A timer whose control field is 0, or 8 to 15 (A and B only), is stopped. Its count holds and its prescaler stays cleared.
- R4: Field values 1 to 7 make a running timer decrement once per 4, 10, 16, 50, 64, 100 or 200 cycles in which tick_i is high. Cycles with tick_i low do not advance the prescaler.
- R5: Writing a data register (addresses 3 to 6 for timers A to D) with 0 sets a reload value of 256. Any other byte sets that value.
- R6: A data write to a stopped timer sets its count to the new reload value in the same clock edge. A data write to a running timer leaves the count unchanged.
- R7: When a stroke arrives at count 1, the count reloads and the timer's bit in timeout_o (bit 0 for A up to bit 3 for D) is high for exactly the next cycle.
- R8: A read of a data register returns the low 8 bits of the live count, so a count of 256 reads as 0x00.
- R9: A control write that changes a timer's field clears that timer's prescaler. A write that leaves the field at the same value does not disturb the prescaler.
- R10: rdata_o is combinational from addr_i. Address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| tick_i | input | 1 | Timer clock enable feeding all prescalers |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| timeout_o | output | 4 | One-cycle expiry pulses, bit n for timer n (A=0) |

## Verification
The bench sets a reload value of 0 and checks that one stroke later the count reads 0xFF. A design that treated 0 literally would instead show an immediate expiry or a stuck count. It changes a control field partway through a prescaler period and confirms the next decrement lands a full period after the write. It also rewrites the same field and confirms that period is not restarted, which catches designs that clear the prescaler on every write or on none. It writes data registers both while a timer runs and while it is stopped. A design that always loaded the count would show the new value at once, and one that never did would keep the stale count. Finally it checks that the reload at expiry uses the value written while the timer was running, that the masked control bits read back as zero, and that control values 8 to 15 freeze the count.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;

  // Terminal prescaler value (ratio minus one) for each select code.
  function automatic int unsigned psc_last(input int unsigned sel);
    case (sel)
      1:       return 3;
      2:       return 9;
      3:       return 15;
      4:       return 49;
      5:       return 63;
      6:       return 99;
      7:       return 199;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/dtmr_prescale.sv
`timescale 1ns/1ps
module dtmr_prescale #(
  parameter int SEL_W = 3,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             stroke_o
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;
  logic [PSC_W-1:0] last;
  logic             psc_en;

  assign last     = PSC_W'(dtmr_pkg::psc_last(int'(sel_i)));
  assign stroke_o = run_i && tick_i && !restart_i && (psc_q == last);
  assign psc_en   = restart_i || !run_i || tick_i;

  always_comb begin
    psc_d = psc_q;
    if (restart_i || !run_i) begin
      psc_d = '0;
    end else if (tick_i) begin
      psc_d = stroke_o ? '0 : psc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
    end else if (psc_en) begin
      psc_q <= psc_d;
    end
  end

endmodule

// File: rtl/dtmr_counter.sv
`timescale 1ns/1ps
module dtmr_counter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              stroke_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_o
);

  localparam logic [CNT_W-1:0] FULL = {1'b1, {DATA_W{1'b0}}};

  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire_q, expire_d;
  logic [CNT_W-1:0] load_wide;
  logic             at_one;

  assign load_wide = (load_val_i == '0) ? FULL : {1'b0, load_val_i};
  assign at_one    = (cnt_q == CNT_W'(1));

  always_comb begin
    reload_d = load_i ? load_wide : reload_q;
    cnt_d    = cnt_q;
    if (load_i && !run_i) begin
      cnt_d = load_wide;
    end else if (stroke_i) begin
      cnt_d = at_one ? reload_q : cnt_q - 1'b1;
    end
    expire_d = stroke_i && at_one;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= FULL;
      cnt_q    <= FULL;
      expire_q <= 1'b0;
    end else begin
      if (load_i) begin
        reload_q <= reload_d;
      end
      if (load_i || stroke_i) begin
        cnt_q <= cnt_d;
      end
      expire_q <= expire_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;

endmodule

// File: rtl/dtmr_quad.sv
`timescale 1ns/1ps
module dtmr_quad #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [3:0]        timeout_o
);

  localparam int CH_N   = 4;
  localparam int SEL_W  = 3;
  localparam int MODE_W = SEL_W + 1;
  localparam int CNT_W  = DATA_W + 1;
  localparam int DATA_BASE = 3;

  logic [CH_N-1:0][MODE_W-1:0] mode_q, mode_d;
  logic [CH_N-1:0]             ctl_hit;
  logic [CH_N-1:0]             restart;
  logic [CH_N-1:0]             run_all;
  logic [CH_N-1:0]             load;
  logic [CH_N-1:0]             stroke;
  logic [CH_N-1:0][CNT_W-1:0]  cnt_all;

  // Control decode: A and B own registers, C and D share one byte.
  always_comb begin
    ctl_hit[0] = wr_en_i && (addr_i == ADDR_W'(0));
    ctl_hit[1] = wr_en_i && (addr_i == ADDR_W'(1));
    ctl_hit[2] = wr_en_i && (addr_i == ADDR_W'(2));
    ctl_hit[3] = ctl_hit[2];
    mode_d[0]  = wdata_i[3:0];
    mode_d[1]  = wdata_i[3:0];
    mode_d[2]  = {1'b0, wdata_i[6:4]};
    mode_d[3]  = {1'b0, wdata_i[2:0]};
  end

  generate
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
      assign restart[ch] = ctl_hit[ch] && (mode_d[ch] != mode_q[ch]);
      assign run_all[ch] = !mode_q[ch][MODE_W-1] && (mode_q[ch][SEL_W-1:0] != '0);
      assign load[ch]    = wr_en_i && (addr_i == ADDR_W'(DATA_BASE + ch));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q[ch] <= '0;
        end else if (ctl_hit[ch]) begin
          mode_q[ch] <= mode_d[ch];
        end
      end

      dtmr_prescale #(.SEL_W(SEL_W), .PSC_W(PSC_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (run_all[ch]),
        .sel_i     (mode_q[ch][SEL_W-1:0]),
        .restart_i (restart[ch]),
        .stroke_o  (stroke[ch])
      );

      dtmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_all[ch]),
        .stroke_i   (stroke[ch]),
        .load_i     (load[ch]),
        .load_val_i (wdata_i),
        .cnt_o      (cnt_all[ch]),
        .expire_o   (timeout_o[ch])
      );
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(0): rdata_o = DATA_W'(mode_q[0]);
      ADDR_W'(1): rdata_o = DATA_W'(mode_q[1]);
      ADDR_W'(2): rdata_o = DATA_W'({1'b0, mode_q[2][SEL_W-1:0], 1'b0, mode_q[3][SEL_W-1:0]});
      ADDR_W'(3): rdata_o = cnt_all[0][DATA_W-1:0];
      ADDR_W'(4): rdata_o = cnt_all[1][DATA_W-1:0];
      ADDR_W'(5): rdata_o = cnt_all[2][DATA_W-1:0];
      ADDR_W'(6): rdata_o = cnt_all[3][DATA_W-1:0];
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/dtmr_quad_chk.sv
`timescale 1ns/1ps
module dtmr_quad_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int CNT_W = DATA_W + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DATA_W-1:0]         wdata_i,
  input logic [DATA_W-1:0]         rdata_o,
  input logic [3:0]                timeout_o,
  input logic [3:0][CNT_W-1:0]     cnt_all,
  input logic [3:0]                run_all
);

  // R2
  ctl_a_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(0)) |-> (rdata_o[DATA_W-1:4] == '0));

  generate
    for (genvar i = 0; i < 4; i++) begin : g_chk
      // R7
      pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o[i] |=> !timeout_o[i]);

      // R7
      pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o[i]) |-> $past(run_all[i]));

      // R3
      stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_all[i] && !(wr_en_i && addr_i == ADDR_W'(3 + i))) |=> $stable(cnt_all[i]));

      // R6
      stopped_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(3 + i) && !run_all[i]) |=>
          (cnt_all[i] == (($past(wdata_i) == '0) ? CNT_W'(1 << DATA_W) : CNT_W'($past(wdata_i)))));

      // R8
      cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_all[i] != '0) && (cnt_all[i] <= CNT_W'(1 << DATA_W)));
    end
  endgenerate

endmodule

bind dtmr_quad dtmr_quad_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .timeout_o (timeout_o),
  .cnt_all   (cnt_all),
  .run_all   (run_all)
);

// File: tb/sim_dtmr_quad.sv
`timescale 1ns/1ps
module sim_dtmr_quad;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [3:0] timeout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dtmr_quad u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .timeout_o (timeout)
  );

  localparam logic [1:0] K_W = 2'd0, K_I = 2'd1, K_R = 2'd2;
  localparam int NV = 67;
  // {kind, addr, value/idle count, expected rdata, expected timeout, requirement}
  localparam logic [28:0] VEC [NV] = '{
    {K_R, 3'd0, 8'h00, 8'h00, 4'h0, 4'd1},   // R1 control A after reset
    {K_R, 3'd3, 8'h00, 8'h00, 4'h0, 4'd8},   // R8 count 256 reads 0x00
    {K_R, 3'd7, 8'h00, 8'h00, 4'h0, 4'd10},  // R10 unused address
    {K_W, 3'd3, 8'h03, 8'h00, 4'h0, 4'd6},
    {K_R, 3'd3, 8'h00, 8'h03, 4'h0, 4'd6},   // R6 stopped write loads
    {K_W, 3'd0, 8'h01, 8'h00, 4'h0, 4'd4},
    {K_R, 3'd3, 8'h00, 8'h03, 4'h0, 4'd4},   // R4
    {K_I, 3'd0, 8'd3,  8'h00, 4'h0, 4'd4},
    {K_R, 3'd3, 8'h00, 8'h03, 4'h0, 4'd4},   // R4 no early stroke
    {K_I, 3'd0, 8'd1,  8'h00, 4'h0, 4'd4},
    {K_R, 3'd3, 8'h00, 8'h02, 4'h0, 4'd4},   // R4 stroke after 4 ticks
    {K_I, 3'd0, 8'd8,  8'h00, 4'h0, 4'd7},
    {K_R, 3'd3, 8'h00, 8'h03, 4'h1, 4'd7},   // R7 reload + pulse
    {K_I, 3'd0, 8'd1,  8'h00, 4'h0, 4'd7},
    {K_R, 3'd3, 8'h00, 8'h03, 4'h0, 4'd7},   // R7 pulse one cycle
    {K_W, 3'd0, 8'h00, 8'h00, 4'h0, 4'd3},
    {K_I, 3'd0, 8'd20, 8'h00, 4'h0, 4'd3},
    {K_R, 3'd3, 8'h00, 8'h03, 4'h0, 4'd3},   // R3 stopped holds
    {K_W, 3'd1, 8'hF0, 8'h00, 4'h0, 4'd2},
    {K_R, 3'd1, 8'h00, 8'h00, 4'h0, 4'd2},   // R2 B keeps low nibble
    {K_W, 3'd2, 8'hFF, 8'h00, 4'h0, 4'd2},
    {K_R, 3'd2, 8'h00, 8'h77, 4'h0, 4'd2},   // R2 shared mask
    {K_W, 3'd2, 8'h00, 8'h00, 4'h0, 4'd2},
    {K_W, 3'd4, 8'h05, 8'h00, 4'h0, 4'd6},
    {K_R, 3'd4, 8'h00, 8'h05, 4'h0, 4'd6},   // R6
    {K_W, 3'd4, 8'h00, 8'h00, 4'h0, 4'd5},
    {K_R, 3'd4, 8'h00, 8'h00, 4'h0, 4'd5},   // R5 zero means 256
    {K_W, 3'd1, 8'h01, 8'h00, 4'h0, 4'd5},
    {K_I, 3'd0, 8'd4,  8'h00, 4'h0, 4'd5},
    {K_R, 3'd4, 8'h00, 8'hFF, 4'h0, 4'd5},   // R5 256 -> 255
    {K_W, 3'd4, 8'h09, 8'h00, 4'h0, 4'd6},
    {K_R, 3'd4, 8'h00, 8'hFF, 4'h0, 4'd6},   // R6 running write keeps count
    {K_W, 3'd1, 8'h00, 8'h00, 4'h0, 4'd3},
    {K_R, 3'd4, 8'h00, 8'hFF, 4'h0, 4'd3},   // R3
    {K_W, 3'd5, 8'h02, 8'h00, 4'h0, 4'd6},
    {K_W, 3'd2, 8'h10, 8'h00, 4'h0, 4'd6},
    {K_W, 3'd5, 8'h07, 8'h00, 4'h0, 4'd6},
    {K_R, 3'd5, 8'h00, 8'h02, 4'h0, 4'd6},   // R6 running write keeps count
    {K_I, 3'd0, 8'd7,  8'h00, 4'h0, 4'd7},
    {K_R, 3'd5, 8'h00, 8'h07, 4'h4, 4'd7},   // R7 reload uses new value
    {K_I, 3'd0, 8'd1,  8'h00, 4'h0, 4'd7},
    {K_R, 3'd5, 8'h00, 8'h07, 4'h0, 4'd7},   // R7
    {K_W, 3'd2, 8'h00, 8'h00, 4'h0, 4'd9},
    {K_W, 3'd3, 8'h02, 8'h00, 4'h0, 4'd9},
    {K_W, 3'd0, 8'h02, 8'h00, 4'h0, 4'd9},
    {K_I, 3'd0, 8'd5,  8'h00, 4'h0, 4'd9},
    {K_W, 3'd0, 8'h01, 8'h00, 4'h0, 4'd9},
    {K_I, 3'd0, 8'd3,  8'h00, 4'h0, 4'd9},
    {K_R, 3'd3, 8'h00, 8'h02, 4'h0, 4'd9},   // R9 restart on change
    {K_I, 3'd0, 8'd1,  8'h00, 4'h0, 4'd9},
    {K_R, 3'd3, 8'h00, 8'h01, 4'h0, 4'd9},   // R9
    {K_W, 3'd0, 8'h01, 8'h00, 4'h0, 4'd9},
    {K_I, 3'd0, 8'd3,  8'h00, 4'h0, 4'd9},
    {K_R, 3'd3, 8'h00, 8'h02, 4'h1, 4'd9},   // R9 same value keeps phase
    {K_W, 3'd0, 8'h09, 8'h00, 4'h0, 4'd3},
    {K_R, 3'd0, 8'h00, 8'h09, 4'h0, 4'd3},   // R3 mode 9 stored
    {K_I, 3'd0, 8'd10, 8'h00, 4'h0, 4'd3},
    {K_R, 3'd3, 8'h00, 8'h02, 4'h0, 4'd3},   // R3 mode 9 stops
    {K_W, 3'd3, 8'h06, 8'h00, 4'h0, 4'd6},
    {K_R, 3'd3, 8'h00, 8'h06, 4'h0, 4'd6},   // R6 loads under mode 9
    {K_W, 3'd6, 8'h01, 8'h00, 4'h0, 4'd4},
    {K_W, 3'd2, 8'h07, 8'h00, 4'h0, 4'd4},
    {K_I, 3'd0, 8'd199, 8'h00, 4'h0, 4'd4},
    {K_R, 3'd6, 8'h00, 8'h01, 4'h0, 4'd4},   // R4 div 200 not yet
    {K_I, 3'd0, 8'd1,  8'h00, 4'h0, 4'd4},
    {K_R, 3'd6, 8'h00, 8'h01, 4'h8, 4'd4},   // R4 div 200 expiry
    {K_W, 3'd2, 8'h00, 8'h00, 4'h0, 4'd4}
  };

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(input logic [2:0] a, input logic [7:0] exp_d,
                       input logic [3:0] exp_t, input int req);
    addr = a;
    #1;
    n_cmp++;
    if (rdata !== exp_d || timeout !== exp_t) begin
      n_bad++;
      $display("FAIL R%0d addr %0d: rdata %h timeout %b, expected %h %b",
               req, a, rdata, timeout, exp_d, exp_t);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][28:27])
        K_W: do_write(VEC[i][26:24], VEC[i][23:16]);
        K_I: idle(int'(VEC[i][23:16]));
        default: check(VEC[i][26:24], VEC[i][15:8], VEC[i][7:4], int'(VEC[i][3:0]));
      endcase
    end

    // R4: cycles with tick low leave the prescaler idle
    do_write(3'd4, 8'h04);
    tick = 1'b0;
    do_write(3'd1, 8'h01);
    idle(20);
    check(3'd4, 8'h04, 4'h0, 4);
    tick = 1'b1;
    idle(4);
    check(3'd4, 8'h03, 4'h0, 4);

    // R1: reset in mid-run clears fields and counts
    rst_n = 1'b0;
    check(3'd1, 8'h00, 4'h0, 1);
    check(3'd4, 8'h00, 4'h0, 1);
    check(3'd2, 8'h00, 4'h0, 1);
    idle(1);
    rst_n = 1'b1;
    idle(10);
    check(3'd4, 8'h00, 4'h0, 1);

    finish_run();
  end

endmodule